// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores incoming frames into host memory using a circular ring of receive descriptors kept in a small local table. Each descriptor has a 16-bit status word, a 16-bit stored length and a 32-bit buffer address. The host fills in the descriptors and marks each one it gives to the block with an ownership flag. It sets the ring's first index, then arms the engine by writing an activation word.

Frames arrive as a byte stream that carries start, end and error marks. For each frame the engine claims the current descriptor, provided it is armed and the descriptor belongs to the engine. It writes the bytes one by one to the descriptor's buffer through a byte write port. At the end of the frame it records the length and error flags, returns ownership to the host and steps to the next descriptor. A per-descriptor flag sends the ring back to entry 0.

If a frame starts while no usable descriptor is ready, the frame is discarded and counted, and the engine disarms itself until the host writes the activation word again.

Top module: `rx_bd_ring`

## Requirements
- R1: A frame is claimed only on a beat with `rx_valid` and `rx_sof` while the engine is armed and status bit 15 (owned-by-engine) of the current descriptor is 1. Each claimed byte n (counting from 0) is written in its own beat, in the same cycle, to buffer address + n.
- R2: The descriptor is updated on the clock edge of the frame's final beat (`rx_eof`). Bit 15 is cleared, bit 11 (last) is set, and bits 14..12 and 10..6 are kept. The length field receives the stored byte count and the buffer address is unchanged.
- R3: After a completed frame the current index moves to 0 if the descriptor had bit 13 (wrap) set or was entry NUM_DESC-1. Otherwise it moves up by one.
- R4: Status bits 5..0 are rewritten at the end of each frame. Bit 0 is set when any beat of the frame had `rx_err`. Bit 1 is set when the frame has fewer than MIN_FRM (64) bytes. Bit 5 is set when it has more than MAX_FRM (1518) bytes. Bits 4..2 are 0.
- R5: Bytes at position BUF_SIZE (1520) and beyond are not written. The stored length is the smaller of the frame length and BUF_SIZE.
- R6: A frame whose first beat finds the engine disarmed or the current descriptor host-owned is discarded. It causes no memory write and no descriptor change. The overrun counter is incremented (saturating) and the engine is disarmed.
- R7: A write of the activation word with bit 24 set arms the engine. A write with bit 24 clear has no effect. Neither write changes the current index, so the next frame re-examines the same descriptor.
- R8: After reset the engine is disarmed, the index is 0, the overrun count is 0 and every descriptor status is 0. A start-index write loads the current index.
- R9: Beats with `rx_valid` low, and beats without `rx_sof` outside a frame, cause no write and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write one full descriptor |
| host_idx | input | IDX_W | Descriptor index for host write |
| host_status | input | 16 | Status word to write |
| host_len | input | 16 | Length word to write |
| host_addr | input | 32 | Buffer address to write |
| host_rd_idx | input | IDX_W | Descriptor index for host read |
| host_rd_status | output | 16 | Status word read |
| host_rd_len | output | 16 | Length word read |
| host_rd_addr | output | 32 | Buffer address read |
| ring_start_wr | input | 1 | Load the current index |
| ring_start_idx | input | IDX_W | Index to load |
| act_wr | input | 1 | Activation register write strobe |
| act_data | input | 32 | Activation write data (bit 24 arms) |
| rx_valid | input | 1 | Stream beat valid |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_err | input | 1 | Receive error on this beat |
| mem_we | output | 1 | Buffer byte write enable |
| mem_addr | output | 32 | Buffer byte address |
| mem_wdata | output | 8 | Buffer byte data |
| rx_active | output | 1 | Engine armed |
| cur_idx | output | IDX_W | Current descriptor index |
| overrun_cnt | output | OVR_W | Discarded frame count |

## Verification
Randomly sized frames of 1 to 300 bytes, with random error beats and idle gaps, are sent around a four-entry ring. Every byte address and every descriptor write-back is compared with a bench model. This separates correct offset counting from off-by-one slips and tells kept status bits apart from rewritten ones. Directed frames of 1, 10, 64 and 1525 bytes check the short, normal and truncated length encodings. A frame sent to a host-owned descriptor and a frame sent while disarmed test the two discard causes separately. Starts at entry 7 and at a flagged entry test implicit wrap and wrap by flag. Activation words with and without bit 24 show that arming responds to that bit alone.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  localparam int ST_OWN  = 15;
  localparam int ST_WRAP = 13;
  localparam int ST_LAST = 11;
  localparam int ACT_BIT = 24;
  localparam logic [15:0] ST_KEEP = 16'h77C0;
  localparam logic [15:0] ST_LASTM = 16'h0800;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RECV = 2'd1,
    S_DROP = 2'd2
  } rx_state_t;
endpackage

// File: rtl/rbr_desc_mem.sv
module rbr_desc_mem #(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic [IDX_W-1:0] hw_idx,
  input  logic [15:0]      hw_status,
  input  logic [15:0]      hw_len,
  input  logic [31:0]      hw_addr,
  input  logic             ew_en,
  input  logic [IDX_W-1:0] ew_idx,
  input  logic [15:0]      ew_status,
  input  logic [15:0]      ew_len,
  input  logic [IDX_W-1:0] er_idx,
  output logic [15:0]      er_status,
  output logic [31:0]      er_addr,
  input  logic [IDX_W-1:0] hr_idx,
  output logic [15:0]      hr_status,
  output logic [15:0]      hr_len,
  output logic [31:0]      hr_addr
);
  logic [NUM_DESC*16-1:0] st_flat;
  logic [NUM_DESC*16-1:0] ln_flat;
  logic [NUM_DESC*32-1:0] ad_flat;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
    logic        hsel, esel;
    logic [15:0] st_r, ln_r;
    logic [31:0] ad_r;
    assign hsel = hw_en && (hw_idx == IDX_W'(g));
    assign esel = ew_en && (ew_idx == IDX_W'(g));

    // engine write-back wins over a host write to the same entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st_r <= '0;
      else if (esel) st_r <= ew_status;
      else if (hsel) st_r <= hw_status;
    end

    always_ff @(posedge clk) begin
      if (esel)      ln_r <= ew_len;
      else if (hsel) ln_r <= hw_len;
    end

    always_ff @(posedge clk) begin
      if (hsel) ad_r <= hw_addr;
    end

    assign st_flat[g*16 +: 16] = st_r;
    assign ln_flat[g*16 +: 16] = ln_r;
    assign ad_flat[g*32 +: 32] = ad_r;
  end

  assign er_status = st_flat[er_idx*16 +: 16];
  assign er_addr   = ad_flat[er_idx*32 +: 32];
  assign hr_status = st_flat[hr_idx*16 +: 16];
  assign hr_len    = ln_flat[hr_idx*16 +: 16];
  assign hr_addr   = ad_flat[hr_idx*32 +: 32];

  // R2: a written-back descriptor is owned by the host afterwards
  a_r2_owner_back: assert property (@(posedge clk) disable iff (!rst_n)
    ew_en |=> !st_flat[$past(ew_idx)*16 + 15]);
endmodule

// File: rtl/rbr_ring_ptr.sv
module rbr_ring_ptr #(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             adv,
  input  logic             wrap,
  output logic [IDX_W-1:0] cur
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  logic [IDX_W-1:0] cur_q, cur_d;
  logic             cur_en;

  always_comb begin
    cur_en = load || adv;
    cur_d  = cur_q;
    if (load)                            cur_d = load_idx;
    else if (wrap || cur_q == LAST_IDX)  cur_d = '0;
    else                                 cur_d = cur_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  assign cur = cur_q;

  // R3: flagged entry leads back to entry 0
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !load) |=> (cur == '0));
  // R3: unflagged inner entry steps by one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !load && cur != LAST_IDX) |=> (cur == IDX_W'($past(cur) + 1'b1)));
endmodule

// File: rtl/rbr_rx_ctrl.sv
module rbr_rx_ctrl
  import rbr_pkg::*;
#(
  parameter int BUF_SIZE = 1520,
  parameter int MAX_FRM  = 1518,
  parameter int MIN_FRM  = 64,
  parameter int OVR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic             rx_err,
  input  logic             act_wr,
  input  logic [31:0]      act_data,
  input  logic [15:0]      d_status,
  input  logic [31:0]      d_addr,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             upd_en,
  output logic [15:0]      upd_status,
  output logic [15:0]      upd_len,
  output logic             adv,
  output logic             wrap,
  output logic             active,
  output logic [OVR_W-1:0] ovr_cnt
);
  localparam logic [15:0] BUF_L = 16'(BUF_SIZE);
  localparam logic [15:0] MAX_L = 16'(MAX_FRM);
  localparam logic [15:0] MIN_L = 16'(MIN_FRM);

  rx_state_t        state_q, state_d;
  logic [15:0]      cnt_q, pos, total;
  logic             err_q, err_now;
  logic             act_q, act_d;
  logic [OVR_W-1:0] ovr_q, ovr_d;
  logic             start_ok, in_frame, take, drop, arm;
  logic [5:0]       errs;

  always_comb begin
    in_frame = (state_q == S_RECV);
    start_ok = rx_valid && rx_sof && act_q && d_status[ST_OWN] && (state_q == S_IDLE);
    drop     = rx_valid && rx_sof && (state_q == S_IDLE) && !start_ok;
    take     = start_ok || (in_frame && rx_valid);
    pos      = in_frame ? cnt_q : 16'd0;
    total    = (pos == 16'hFFFF) ? pos : pos + 16'd1;
    err_now  = (in_frame && err_q) || rx_err;
    arm      = act_wr && act_data[ACT_BIT];

    mem_we    = take && (pos < BUF_L);
    mem_addr  = d_addr + 32'(pos);
    mem_wdata = rx_data;

    errs       = {total > MAX_L, 3'b000, total < MIN_L, err_now};
    upd_en     = take && rx_eof;
    upd_len    = (total > BUF_L) ? BUF_L : total;
    upd_status = (d_status & ST_KEEP) | ST_LASTM | {10'd0, errs};
    adv        = upd_en;
    wrap       = d_status[ST_WRAP];

    state_d = state_q;
    case (state_q)
      S_IDLE: if (start_ok && !rx_eof)  state_d = S_RECV;
              else if (drop && !rx_eof) state_d = S_DROP;
      S_RECV: if (rx_valid && rx_eof)   state_d = S_IDLE;
      S_DROP: if (rx_valid && rx_eof)   state_d = S_IDLE;
      default:                          state_d = S_IDLE;
    endcase

    act_d = act_q;
    if (arm)       act_d = 1'b1;
    else if (drop) act_d = 1'b0;

    ovr_d = (ovr_q == {OVR_W{1'b1}}) ? ovr_q : ovr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      act_q   <= 1'b0;
      ovr_q   <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
      if (drop) ovr_q <= ovr_d;
      if (take) begin
        cnt_q <= total;
        err_q <= err_now;
      end
    end
  end

  assign active  = act_q;
  assign ovr_cnt = ovr_q;

  // R1: buffer writes happen only while armed
  a_r1_write_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> act_q);
  // R6: nothing is written while discarding a frame
  a_r6_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DROP) |-> !mem_we);
  // R6: a discard without a new activation leaves the engine disarmed
  a_r6_drop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !arm) |=> !active);
  // R5: stored length never exceeds the buffer size
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (upd_len <= BUF_L));
  // R2: a write-back never leaves the descriptor owned by the engine
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (!upd_status[ST_OWN] && upd_status[ST_LAST]));
endmodule

// File: rtl/rx_bd_ring.sv
module rx_bd_ring #(
  parameter int NUM_DESC = 8,
  parameter int BUF_SIZE = 1520,
  parameter int MAX_FRM  = 1518,
  parameter int MIN_FRM  = 64,
  parameter int OVR_W    = 8,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [15:0]      host_status,
  input  logic [15:0]      host_len,
  input  logic [31:0]      host_addr,
  input  logic [IDX_W-1:0] host_rd_idx,
  output logic [15:0]      host_rd_status,
  output logic [15:0]      host_rd_len,
  output logic [31:0]      host_rd_addr,
  input  logic             ring_start_wr,
  input  logic [IDX_W-1:0] ring_start_idx,
  input  logic             act_wr,
  input  logic [31:0]      act_data,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic             rx_err,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             rx_active,
  output logic [IDX_W-1:0] cur_idx,
  output logic [OVR_W-1:0] overrun_cnt
);
  logic [15:0] d_status, upd_status, upd_len;
  logic [31:0] d_addr;
  logic        upd_en, adv, wrap;

  rbr_desc_mem #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .hw_en(host_wr), .hw_idx(host_idx), .hw_status(host_status),
    .hw_len(host_len), .hw_addr(host_addr),
    .ew_en(upd_en), .ew_idx(cur_idx), .ew_status(upd_status), .ew_len(upd_len),
    .er_idx(cur_idx), .er_status(d_status), .er_addr(d_addr),
    .hr_idx(host_rd_idx), .hr_status(host_rd_status),
    .hr_len(host_rd_len), .hr_addr(host_rd_addr)
  );

  rbr_ring_ptr #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(ring_start_wr), .load_idx(ring_start_idx),
    .adv(adv), .wrap(wrap), .cur(cur_idx)
  );

  rbr_rx_ctrl #(.BUF_SIZE(BUF_SIZE), .MAX_FRM(MAX_FRM), .MIN_FRM(MIN_FRM),
                .OVR_W(OVR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_err(rx_err),
    .act_wr(act_wr), .act_data(act_data),
    .d_status(d_status), .d_addr(d_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .upd_en(upd_en), .upd_status(upd_status), .upd_len(upd_len),
    .adv(adv), .wrap(wrap), .active(rx_active), .ovr_cnt(overrun_cnt)
  );
endmodule

// File: tb/rx_bd_ring_bench.sv
module rx_bd_ring_bench;
  localparam int N   = 8;
  localparam int BUF = 1520;

  logic        clk, rst_n;
  logic        host_wr;
  logic [2:0]  host_idx, host_rd_idx, ring_start_idx, cur_idx;
  logic [15:0] host_status, host_len, host_rd_status, host_rd_len;
  logic [31:0] host_addr, host_rd_addr, act_data, mem_addr;
  logic        ring_start_wr, act_wr;
  logic        rx_valid, rx_sof, rx_eof, rx_err;
  logic [7:0]  rx_data, mem_wdata;
  logic        mem_we, rx_active;
  logic [7:0]  overrun_cnt;

  rx_bd_ring #(.NUM_DESC(N)) u_rx_bd_ring (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_idx(host_idx), .host_status(host_status),
    .host_len(host_len), .host_addr(host_addr),
    .host_rd_idx(host_rd_idx), .host_rd_status(host_rd_status),
    .host_rd_len(host_rd_len), .host_rd_addr(host_rd_addr),
    .ring_start_wr(ring_start_wr), .ring_start_idx(ring_start_idx),
    .act_wr(act_wr), .act_data(act_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_err(rx_err),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rx_active(rx_active), .cur_idx(cur_idx), .overrun_cnt(overrun_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total_n = 0;
  int bad_n   = 0;

  logic [15:0] m_st [N];
  logic [31:0] m_ad [N];
  int          m_cur;
  bit          m_act;
  int          m_ovr;

  task automatic chk(string req, longint act, longint exp);
    total_n++;
    if (act != exp) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_st(logic [15:0] old, int tot, bit e);
    logic [15:0] r;
    r = (old & 16'h77C0) | 16'h0800;
    r[0] = e;
    r[1] = (tot < 64);
    r[5] = (tot > 1518);
    return r;
  endfunction

  function automatic int exp_len(int tot);
    return (tot > BUF) ? BUF : tot;
  endfunction

  task automatic host_desc(int idx, logic [15:0] st, logic [31:0] ad);
    @(negedge clk);
    host_wr = 1'b1; host_idx = 3'(idx); host_status = st;
    host_len = 16'h0; host_addr = ad;
    @(negedge clk);
    host_wr = 1'b0;
    m_st[idx] = st; m_ad[idx] = ad;
  endtask

  task automatic activate(logic [31:0] d);
    @(negedge clk);
    act_wr = 1'b1; act_data = d;
    @(negedge clk);
    act_wr = 1'b0;
    if (d[24]) m_act = 1'b1;
    #1;
    chk("R7 armed state", rx_active, m_act);
    chk("R7 index kept", cur_idx, m_cur);
  endtask

  task automatic set_start(int idx);
    @(negedge clk);
    ring_start_wr = 1'b1; ring_start_idx = 3'(idx);
    @(negedge clk);
    ring_start_wr = 1'b0;
    m_cur = idx;
    #1;
    chk("R8 start load", cur_idx, idx);
  endtask

  task automatic send_frame(int n, int errbeat, bit gaps, string req);
    int  c   = m_cur;
    bit  acc = m_act && m_st[c][15];
    int  miss = 0;
    bit  e   = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'($urandom);
        #1;
        if (mem_we) miss++;   // R9 idle beat ignored
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1);
      rx_err = (i == errbeat); rx_data = 8'($urandom);
      if (i == errbeat) e = 1'b1;
      #1;
      if (mem_we != (acc && i < BUF)) miss++;
      else if (mem_we && (mem_addr != m_ad[c] + 32'(i) || mem_wdata != rx_data)) miss++;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    chk({req, " R1 byte writes"}, miss, 0);
    if (acc) begin
      m_st[c] = exp_st(m_st[c], n, e);
      m_cur = (m_st[c][13] || c == N - 1) ? 0 : c + 1;
    end else begin
      m_ovr++;
      m_act = 1'b0;
    end
    host_rd_idx = 3'(c);
    #1;
    chk({req, " R2/R4 status"}, host_rd_status, m_st[c]);
    if (acc) chk({req, " R2/R5 length"}, host_rd_len, exp_len(n));
    chk({req, " R2 address kept"}, host_rd_addr, m_ad[c]);
    chk({req, " R3 index"}, cur_idx, m_cur);
    chk({req, " R6 overrun"}, overrun_cnt, m_ovr);
    chk({req, " R6 armed"}, rx_active, m_act);
  endtask

  task automatic rearm(int idx, bit wrapf);
    host_desc(idx, 16'h8000 | (wrapf ? 16'h2000 : 16'h0) | (16'($urandom) & 16'h17FF),
              32'h1000 * (idx + 1) + 32'($urandom % 64));
  endtask

  initial begin
    #(20 * 150000);
    bad_n++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    rst_n = 1'b0; host_wr = 0; host_idx = 0; host_status = 0; host_len = 0;
    host_addr = 0; host_rd_idx = 0; ring_start_wr = 0; ring_start_idx = 0;
    act_wr = 0; act_data = 0; rx_valid = 0; rx_data = 0; rx_sof = 0;
    rx_eof = 0; rx_err = 0;
    m_cur = 0; m_act = 0; m_ovr = 0;
    for (int i = 0; i < N; i++) begin m_st[i] = 0; m_ad[i] = 0; end
    #55;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 reset armed", rx_active, 0);
    chk("R8 reset index", cur_idx, 0);
    chk("R8 reset overrun", overrun_cnt, 0);
    host_rd_idx = 3'd5; #1;
    chk("R8 reset status", host_rd_status, 0);

    for (int i = 0; i < 4; i++) rearm(i, i == 3);
    set_start(0);
    send_frame(70, -1, 1'b0, "R6 disarmed");
    activate(32'h0000_0001);
    activate(32'h0100_0000);

    // R9 stray beat without start mark
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = 1'b1; #1;
    chk("R9 stray beat write", mem_we, 0);
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b0; #1;
    chk("R9 stray beat index", cur_idx, m_cur);

    send_frame(64, -1, 1'b0, "R1 normal");
    send_frame(100, 37, 1'b1, "R4 error beat");
    send_frame(10, -1, 1'b0, "R4 short");
    send_frame(1, -1, 1'b0, "R4 single");
    send_frame(80, -1, 1'b0, "R6 host owned");
    for (int i = 0; i < 4; i++) rearm(i, i == 3);
    activate(32'h0100_0000);
    send_frame(BUF + 5, -1, 1'b0, "R5 truncated");
    send_frame(1519, -1, 1'b0, "R4 over max");

    for (int k = 0; k < 14; k++) begin
      if (!m_st[m_cur][15] && ($urandom % 4 != 0)) rearm(m_cur, m_cur == 3);
      if (!m_act) activate(32'h0100_0000);
      send_frame(1 + $urandom % 300, ($urandom % 3 == 0) ? int'($urandom % 8) : -1,
                 1'b1, "rand");
    end

    rearm(7, 1'b0);
    set_start(7);
    activate(32'h0100_0000);
    send_frame(66, -1, 1'b0, "R3 last entry");

    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule